// File: doc/BRIEF.md
# Serial Memory Command Front End (SPI mode 0)

This block is the slave-side command decoder of a serial non-volatile byte memory. It samples the SPI pins with a fast system clock, gathers an 8-bit instruction byte, then an optional 16-bit byte address and data bytes, and turns them into single-cycle strobes for the status logic and the array write path. For array and status reads, it serialises bytes onto a data-out pin that has its own output enable. The enable is meant to drive a tri-state pad buffer. The array storage, write timing and protection logic sit outside the block. The block gives them an address, write data and strobes, and takes back read data, the status byte and a write-busy flag.

Reads stream without a break: after every byte the address advances, and it wraps from the top of the array to zero. Writes issue one strobe per received byte. Between strobes the address advances only inside a page of `2**PAGE_BITS` bytes. A pause input freezes a transfer in progress, and a deselect always clears the sequence.

Top module: `spi_mem_cmd_if`

## Requirements
- R1: Bits on the data-in pin are taken on serial-clock rising edges, most significant bit first. The first byte after select is the instruction. Its upper nibble must be 0000, bit 3 is ignored, and bits 2..0 select the command: 110 set-write-enable, 100 clear-write-enable, 101 status read, 001 status write, 011 array read, 010 array write.
- R2: An instruction byte that is not valid makes the block ignore every following bit and keep the output enable low until chip select has gone high and low again.
- R3: While chip select (active low) is high, the output enable is low and the data-in pin is ignored. A deselect in the middle of a byte discards the partial sequence.
- R4: Array read and array write take a 16-bit address after the instruction. Only its low `ADDR_W` bits are kept. In an array read, the output enable rises and the first data bit appears only after the serial-clock falling edge that follows the last address bit.
- R5: An array read returns successive bytes while chip select stays low. The address increments after each byte and wraps from the top address to 0.
- R6: An array write emits one `arr_wr_o` strobe per complete data byte, with that byte and its address. The next address increments only the low `PAGE_BITS` bits; the upper bits are kept.
- R7: A status read drives the status byte repeatedly. A status write emits exactly one `stat_wr_o` strobe carrying the first data byte, and ignores later bytes.
- R8: With the pause input low while the serial clock is low, the output enable is low, and both data-in and serial-clock edges are ignored. Raising the pause input while the serial clock is low resumes the transfer where it stopped.
- R9: While `wr_busy_i` is high when an instruction byte completes, every instruction except status read is ignored.
- R10: After reset the output enable is low, no strobe is active, and at most one strobe is active in any cycle.
- R11: Set-write-enable and clear-write-enable each produce exactly one single-cycle strobe per instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock (asynchronous) |
| cs_n_i | input | 1 | Chip select, active low (asynchronous) |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the data-out pad |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status byte returned by status read |
| rd_data_i | input | 8 | Array byte at `arr_addr_o` |
| wen_set_o | output | 1 | Set-write-enable strobe |
| wen_clr_o | output | 1 | Clear-write-enable strobe |
| stat_wr_o | output | 1 | Status write strobe |
| stat_wdata_o | output | 8 | Status write data |
| arr_wr_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | ADDR_W | Array address for reads and writes |
| arr_wdata_o | output | 8 | Array write data |

## Verification
A corrupted bit counter or shift register shows up at once as a wrong strobe address or data byte. A read stream shows it within one byte, as a misaligned or wrong value on the data-out pin. A state machine left in the wrong state after a deselect shows on the first instruction of the next selection, either as a missing strobe or as an output enable in the wrong phase. A pause flag that is stuck or never set shows as the output enable staying high while paused, or as extra bits being absorbed into the byte that resumes.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

   typedef enum logic [2:0] {
      ST_OPC, ST_ADDR, ST_RDAT, ST_STAT, ST_WDAT, ST_WSR, ST_LOCK
   } fe_state_t;

   typedef enum logic [2:0] {
      OP_NONE, OP_WEN_SET, OP_WEN_CLR, OP_STAT_RD, OP_STAT_WR, OP_ARR_RD, OP_ARR_WR
   } fe_op_t;

   // upper nibble must be zero, bit 3 is ignored
   function automatic fe_op_t decode_op(input logic [7:0] b);
      fe_op_t r;
      r = OP_NONE;
      if (b[7:4] == 4'h0) begin
         case (b[2:0])
            3'b110:  r = OP_WEN_SET;
            3'b100:  r = OP_WEN_CLR;
            3'b101:  r = OP_STAT_RD;
            3'b001:  r = OP_STAT_WR;
            3'b011:  r = OP_ARR_RD;
            3'b010:  r = OP_ARR_WR;
            default: r = OP_NONE;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int          WIDTH   = 4,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_in_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d_i;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          shift_i,
   input  logic [DW-1:0] din_i,
   output logic          so_o
);

   logic [DW-1:0] sr;
   logic          so_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         so_q <= 1'b0;
      end else if (load_i) begin
         so_q <= din_i[DW-1];
         sr   <= {din_i[DW-2:0], 1'b0};
      end else if (shift_i) begin
         so_q <= sr[DW-1];
         sr   <= {sr[DW-2:0], 1'b0};
      end
   end

   assign so_o = so_q;

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
   import spi_mem_pkg::*;
#(
   parameter int AW = 11,
   parameter int PB = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_hi_i,
   input  logic          sck_i,
   input  logic          si_i,
   input  logic          hold_n_i,
   input  logic          wr_busy_i,
   input  logic [7:0]    status_i,
   input  logic [7:0]    rd_data_i,
   output logic          held_o,
   output logic          wen_set_o,
   output logic          wen_clr_o,
   output logic          stat_wr_o,
   output logic [7:0]    stat_wdata_o,
   output logic          arr_wr_o,
   output logic [7:0]    arr_wdata_o,
   output logic [AW-1:0] addr_o,
   output logic          tx_load_o,
   output logic          tx_shift_o,
   output logic [7:0]    tx_din_o,
   output logic          so_oe_o
);

   fe_state_t     st;
   logic [15:0]   sh;
   logic [3:0]    cnt;
   logic [2:0]    txcnt;
   logic          tx_live, is_wr, sck_prev;
   logic [AW-1:0] addr_step;

   wire        sck_rise = sck_i & ~sck_prev;
   wire        sck_fall = ~sck_i & sck_prev;
   wire        rise_ok  = sck_rise & ~held_o & ~cs_hi_i;
   wire        fall_ok  = sck_fall & ~held_o & ~cs_hi_i;
   wire        rd_state = (st == ST_RDAT) || (st == ST_STAT);
   wire [7:0]  byte_in  = {sh[6:0], si_i};
   wire [15:0] word_in  = {sh[14:0], si_i};
   fe_op_t     op;
   assign op = decode_op(byte_in);

   generate
      if (AW < 1 || AW > 16 || PB < 0 || PB > AW) begin : g_bad_cfg
         $error("spi_cmd_fsm: AW must be 1..16 and PB 0..AW");
      end
      if (PB == 0 || PB == AW) begin : g_full_inc
         assign addr_step = addr_o + 1'b1;
      end else begin : g_page_inc
         assign addr_step = {addr_o[AW-1:PB], addr_o[PB-1:0] + 1'b1};
      end
   endgenerate

   // pause takes effect only while the serial clock is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_o <= 1'b0;
      else if (cs_hi_i) held_o <= 1'b0;
      else if (!sck_i)  held_o <= ~hold_n_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_OPC;
         sh           <= '0;
         cnt          <= '0;
         txcnt        <= '0;
         tx_live      <= 1'b0;
         is_wr        <= 1'b0;
         sck_prev     <= 1'b0;
         addr_o       <= '0;
         wen_set_o    <= 1'b0;
         wen_clr_o    <= 1'b0;
         stat_wr_o    <= 1'b0;
         arr_wr_o     <= 1'b0;
         stat_wdata_o <= '0;
         arr_wdata_o  <= '0;
      end else begin
         sck_prev  <= sck_i;
         wen_set_o <= 1'b0;
         wen_clr_o <= 1'b0;
         stat_wr_o <= 1'b0;
         arr_wr_o  <= 1'b0;
         if (arr_wr_o) addr_o <= addr_step;
         if (cs_hi_i) begin
            st      <= ST_OPC;
            cnt     <= '0;
            txcnt   <= '0;
            tx_live <= 1'b0;
         end else if (rise_ok) begin
            case (st)
               ST_OPC: begin
                  sh  <= word_in;
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd7) begin
                     cnt   <= '0;
                     is_wr <= (op == OP_ARR_WR);
                     if (wr_busy_i && op != OP_STAT_RD) st <= ST_LOCK;
                     else begin
                        case (op)
                           OP_WEN_SET: begin wen_set_o <= 1'b1; st <= ST_LOCK; end
                           OP_WEN_CLR: begin wen_clr_o <= 1'b1; st <= ST_LOCK; end
                           OP_STAT_RD: st <= ST_STAT;
                           OP_STAT_WR: st <= ST_WSR;
                           OP_ARR_RD,
                           OP_ARR_WR:  st <= ST_ADDR;
                           default:    st <= ST_LOCK;
                        endcase
                     end
                  end
               end
               ST_ADDR: begin
                  sh  <= word_in;
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd15) begin
                     cnt    <= '0;
                     addr_o <= word_in[AW-1:0];
                     st     <= is_wr ? ST_WDAT : ST_RDAT;
                  end
               end
               ST_WDAT, ST_WSR: begin
                  sh  <= word_in;
                  cnt <= cnt + 4'd1;
                  if (cnt == 4'd7) begin
                     cnt <= '0;
                     if (st == ST_WDAT) begin
                        arr_wdata_o <= byte_in;
                        arr_wr_o    <= 1'b1;
                     end else begin
                        stat_wdata_o <= byte_in;
                        stat_wr_o    <= 1'b1;
                        st           <= ST_LOCK;
                     end
                  end
               end
               default: ;
            endcase
         end else if (fall_ok && rd_state) begin
            txcnt   <= txcnt + 3'd1;
            tx_live <= 1'b1;
            if (txcnt == 3'd7 && st == ST_RDAT) addr_o <= addr_o + 1'b1;
         end
      end
   end

   assign tx_load_o  = fall_ok & rd_state & (txcnt == 3'd0);
   assign tx_shift_o = fall_ok & rd_state & (txcnt != 3'd0);
   assign tx_din_o   = (st == ST_STAT) ? status_i : rd_data_i;
   assign so_oe_o    = tx_live & ~held_o & rd_state & ~cs_hi_i;

endmodule

// File: rtl/spi_mem_cmd_if.sv
module spi_mem_cmd_if #(
   parameter int ADDR_W      = 11,
   parameter int PAGE_BITS   = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_i,
   input  logic              cs_n_i,
   input  logic              si_i,
   input  logic              hold_n_i,
   output logic              so_o,
   output logic              so_oe_o,
   input  logic              wr_busy_i,
   input  logic [7:0]        status_i,
   input  logic [7:0]        rd_data_i,
   output logic              wen_set_o,
   output logic              wen_clr_o,
   output logic              stat_wr_o,
   output logic [7:0]        stat_wdata_o,
   output logic              arr_wr_o,
   output logic [ADDR_W-1:0] arr_addr_o,
   output logic [7:0]        arr_wdata_o
);

   localparam int NPIN = 4;
   // pin order {hold_n, si, cs_n, sck}; idle pins reset to deselected
   localparam logic [NPIN-1:0] PIN_IDLE = 4'b1010;

   logic [NPIN-1:0] pins_s;
   logic            cs_lvl, held, tx_load, tx_shift;
   logic [7:0]      tx_din;

   spi_in_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({hold_n_i, si_i, cs_n_i, sck_i}),
      .q_o   (pins_s)
   );

   assign cs_lvl = pins_s[1];

   spi_cmd_fsm #(.AW(ADDR_W), .PB(PAGE_BITS)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_hi_i      (cs_lvl),
      .sck_i        (pins_s[0]),
      .si_i         (pins_s[2]),
      .hold_n_i     (pins_s[3]),
      .wr_busy_i    (wr_busy_i),
      .status_i     (status_i),
      .rd_data_i    (rd_data_i),
      .held_o       (held),
      .wen_set_o    (wen_set_o),
      .wen_clr_o    (wen_clr_o),
      .stat_wr_o    (stat_wr_o),
      .stat_wdata_o (stat_wdata_o),
      .arr_wr_o     (arr_wr_o),
      .arr_wdata_o  (arr_wdata_o),
      .addr_o       (arr_addr_o),
      .tx_load_o    (tx_load),
      .tx_shift_o   (tx_shift),
      .tx_din_o     (tx_din),
      .so_oe_o      (so_oe_o)
   );

   spi_tx_shift #(.DW(8)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (tx_load),
      .shift_i (tx_shift),
      .din_i   (tx_din),
      .so_o    (so_o)
   );

endmodule

// File: rtl/spi_mem_cmd_chk.sv
module spi_mem_cmd_chk #(
   parameter int AW = 11,
   parameter int PB = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_hi,
   input logic          held,
   input logic          so_oe,
   input logic          wr_busy,
   input logic          wen_set,
   input logic          wen_clr,
   input logic          stat_wr,
   input logic          arr_wr,
   input logic [AW-1:0] arr_addr
);

   localparam logic [AW-1:0] PMASK = (PB == 0) ? {AW{1'b1}} : AW'((1 << PB) - 1);

   function automatic logic [AW-1:0] page_next(input logic [AW-1:0] a);
      return (a & ~PMASK) | ((a + 1'b1) & PMASK);
   endfunction

   // R3
   cs_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi && $past(cs_hi) |-> !so_oe);

   // R10
   strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wen_set, wen_clr, stat_wr, arr_wr}));

   // R9
   busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_busy) |-> !wen_set && !wen_clr);

   // R6
   page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr |=> arr_addr == page_next($past(arr_addr)));

   // R8
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held && $past(held) |-> $stable(arr_addr) && !arr_wr);

endmodule

bind spi_mem_cmd_if spi_mem_cmd_chk #(.AW(ADDR_W), .PB(PAGE_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_hi    (cs_lvl),
   .held     (held),
   .so_oe    (so_oe_o),
   .wr_busy  (wr_busy_i),
   .wen_set  (wen_set_o),
   .wen_clr  (wen_clr_o),
   .stat_wr  (stat_wr_o),
   .arr_wr   (arr_wr_o),
   .arr_addr (arr_addr_o)
);

// File: tb/tb_spi_mem_cmd_if.sv
module tb_spi_mem_cmd_if;

   localparam int AW = 11;
   localparam int HALF = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
   logic [7:0] status = 8'h8C;
   logic so, so_oe, wen_set, wen_clr, stat_wr, arr_wr;
   logic [7:0] stat_wdata, arr_wdata, rd_data;
   logic [AW-1:0] arr_addr;

   int n_checks = 0, n_err = 0;
   int n_set = 0, n_clr = 0, n_wsr = 0, n_aw = 0;
   logic [7:0]    last_wsr;
   logic [AW-1:0] aw_addr [8];
   logic [7:0]    aw_data [8];

   always #10 clk = ~clk;

   function automatic logic [7:0] mdat(input logic [AW-1:0] a);
      return a[7:0] ^ {a[10:8], 5'h0B};
   endfunction
   assign rd_data = mdat(arr_addr);

   spi_mem_cmd_if dut (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
      .hold_n_i(hold_n), .so_o(so), .so_oe_o(so_oe), .wr_busy_i(busy),
      .status_i(status), .rd_data_i(rd_data), .wen_set_o(wen_set),
      .wen_clr_o(wen_clr), .stat_wr_o(stat_wr), .stat_wdata_o(stat_wdata),
      .arr_wr_o(arr_wr), .arr_addr_o(arr_addr), .arr_wdata_o(arr_wdata)
   );

   always @(negedge clk) begin
      if (wen_set) n_set++;
      if (wen_clr) n_clr++;
      if (stat_wr) begin n_wsr++; last_wsr = stat_wdata; end
      if (arr_wr) begin
         if (n_aw < 8) begin aw_addr[n_aw] = arr_addr; aw_data[n_aw] = arr_wdata; end
         n_aw++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic spi_bit(input logic b, output logic so_s, output logic oe_s);
      si = b;
      repeat (HALF) @(negedge clk);
      so_s = so; oe_s = so_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      oe_s = oe_s | so_oe;
      sck = 1'b0;
   endtask

   task automatic spi_byte(input logic [7:0] b, output logic [7:0] r, output logic oe_any);
      logic s, o;
      oe_any = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         spi_bit(b[i], s, o);
         r[i] = s;
         oe_any = oe_any | o;
      end
   endtask

   task automatic sel();
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic desel();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   // {opcode, set delta, clear delta, output enabled with status}
   localparam logic [10:0] VEC [9] = '{
      {8'h06, 3'b100}, {8'h0E, 3'b100}, {8'h04, 3'b010}, {8'h0C, 3'b010},
      {8'h05, 3'b001}, {8'h0D, 3'b001}, {8'hFF, 3'b000}, {8'h46, 3'b000},
      {8'h00, 3'b000}
   };

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      logic [7:0] r;
      logic oe, s, o;
      int s0, c0, w0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R10 reset state
      chk(so_oe == 1'b0, "R10 oe after reset", so_oe, 0);
      chk(n_set + n_clr + n_wsr + n_aw == 0, "R10 no strobe after reset", n_set + n_clr + n_wsr + n_aw, 0);

      // R1 R11 R7 R2 opcode table
      foreach (VEC[k]) begin
         s0 = n_set; c0 = n_clr;
         sel();
         spi_byte(VEC[k][10:3], r, oe);
         spi_byte(8'h00, r, oe);
         desel();
         chk(n_set - s0 == int'(VEC[k][2]), "R11 set strobe count", n_set - s0, VEC[k][2]);
         chk(n_clr - c0 == int'(VEC[k][1]), "R11 clear strobe count", n_clr - c0, VEC[k][1]);
         chk(oe == VEC[k][0], "R1 output enable per opcode", oe, VEC[k][0]);
         if (VEC[k][0]) chk(r == status, "R7 status byte", r, status);
      end

      // R2 invalid opcode locks until reselect
      s0 = n_set;
      sel();
      spi_byte(8'h83, r, oe);
      spi_byte(8'h06, r, oe);
      spi_byte(8'h05, r, o);
      desel();
      chk(n_set == s0 && !oe && !o, "R2 locked after invalid opcode", n_set - s0, 0);

      // R3 deselect mid-byte discards partial opcode
      sel();
      for (int i = 0; i < 4; i++) spi_bit(1'b1, s, o);
      desel();
      s0 = n_set;
      sel();
      spi_byte(8'h06, r, oe);
      desel();
      chk(n_set - s0 == 1, "R3 sequence restarts after deselect", n_set - s0, 1);
      chk(so_oe == 1'b0, "R3 oe low while deselected", so_oe, 0);

      // R4 R5 read with ignored upper address bits and wrap
      sel();
      spi_byte(8'h03, r, oe);
      spi_byte(8'hFF, r, oe);
      spi_byte(8'hFE, r, o);
      chk(!oe && !o, "R4 oe low through address phase", o, 0);
      spi_byte(8'h00, r, oe);
      chk(r == mdat(11'h7FE) && oe, "R4 first read byte", r, mdat(11'h7FE));
      spi_byte(8'h00, r, oe);
      chk(r == mdat(11'h7FF), "R5 second read byte", r, mdat(11'h7FF));
      spi_byte(8'h00, r, oe);
      chk(r == mdat(11'h000), "R5 read wraps to zero", r, mdat(11'h000));
      spi_byte(8'h00, r, oe);
      chk(r == mdat(11'h001), "R5 read after wrap", r, mdat(11'h001));
      desel();

      // R8 pause in the middle of a read byte
      sel();
      spi_byte(8'h0B, r, oe);
      spi_byte(8'h01, r, oe);
      spi_byte(8'h00, r, oe);
      spi_byte(8'h00, r, oe);
      chk(r == mdat(11'h100), "R4 read with bit 3 set", r, mdat(11'h100));
      for (int i = 7; i >= 4; i--) begin spi_bit(1'b0, s, o); r[i] = s; end
      hold_n = 1'b0;
      repeat (2 * HALF) @(negedge clk);
      chk(so_oe == 1'b0, "R8 oe low while paused", so_oe, 0);
      for (int i = 0; i < 3; i++) begin
         spi_bit(1'b1, s, o);
         chk(o == 1'b0, "R8 oe stays low with clock toggling", o, 0);
      end
      hold_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
      for (int i = 3; i >= 0; i--) begin spi_bit(1'b0, s, o); r[i] = s; end
      chk(r == mdat(11'h101), "R8 read resumes intact", r, mdat(11'h101));
      desel();

      // R6 R8 page write with a pause inside the first byte
      w0 = n_aw;
      sel();
      spi_byte(8'h02, r, oe);
      spi_byte(8'h00, r, oe);
      spi_byte(8'h3E, r, oe);
      for (int i = 7; i >= 4; i--) spi_bit(r[0] ^ r[0] ^ 8'h11 >> i, s, o);
      hold_n = 1'b0;
      repeat (2 * HALF) @(negedge clk);
      for (int i = 0; i < 3; i++) spi_bit(1'b1, s, o);
      hold_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
      for (int i = 3; i >= 0; i--) spi_bit(8'h11 >> i, s, o);
      spi_byte(8'h22, r, oe);
      spi_byte(8'h33, r, oe);
      desel();
      chk(n_aw - w0 == 3, "R6 write strobe count", n_aw - w0, 3);
      chk(aw_addr[w0] == 11'h03E && aw_data[w0] == 8'h11, "R8 write byte across pause", {aw_addr[w0], aw_data[w0]}, {11'h03E, 8'h11});
      chk(aw_addr[w0+1] == 11'h03F && aw_data[w0+1] == 8'h22, "R6 second write", {aw_addr[w0+1], aw_data[w0+1]}, {11'h03F, 8'h22});
      chk(aw_addr[w0+2] == 11'h020 && aw_data[w0+2] == 8'h33, "R6 page wrap", {aw_addr[w0+2], aw_data[w0+2]}, {11'h020, 8'h33});

      // R7 status write takes the first byte only
      w0 = n_wsr;
      sel();
      spi_byte(8'h01, r, oe);
      spi_byte(8'hA5, r, oe);
      spi_byte(8'h3C, r, oe);
      desel();
      chk(n_wsr - w0 == 1 && last_wsr == 8'hA5, "R7 single status write", last_wsr, 8'hA5);

      // R9 busy: only status read acts
      busy = 1'b1;
      s0 = n_set; w0 = n_aw;
      sel(); spi_byte(8'h06, r, oe); desel();
      chk(n_set == s0, "R9 set refused while busy", n_set - s0, 0);
      sel();
      spi_byte(8'h03, r, oe);
      spi_byte(8'h00, r, oe);
      spi_byte(8'h10, r, o);
      spi_byte(8'h00, r, oe);
      desel();
      chk(!oe && !o, "R9 read refused while busy", oe, 0);
      sel();
      spi_byte(8'h02, r, oe); spi_byte(8'h00, r, oe);
      spi_byte(8'h10, r, oe); spi_byte(8'h77, r, oe);
      desel();
      chk(n_aw == w0, "R9 write refused while busy", n_aw - w0, 0);
      status = 8'hF1;
      sel();
      spi_byte(8'h05, r, oe);
      spi_byte(8'h00, r, oe);
      chk(r == 8'hF1 && oe, "R9 status read while busy", r, 8'hF1);
      spi_byte(8'h00, r, oe);
      chk(r == 8'hF1, "R7 status byte repeats", r, 8'hF1);
      desel();
      busy = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule